// File: doc/BRIEF.md
# UART Receive Status and Interrupt Logic

This block sits behind the bit-sampling stage of a UART receiver and in front of the CPU register interface. When the sampling stage reports a finished character, the block captures it into a receive data register and records the per-character results: noise, parity error and a low stop bit. It also watches the sampled line level at each bit time so it can report an idle line. A character that completes while the register still holds an unread one is dropped, and the overrun flag is raised instead.

Software clears flags with a two-step sequence: first a status read, then a data read. Only flags that were set at the status read are cleared, and only if they did not set again before the data read. Two level-sensitive interrupt lines leave the block. One serves receiver events (receive-full and idle). The other serves errors (overrun, noise, framing and parity). Every flag has its own enable.

Top module: `uart_rx_status`

## Requirements
- R1: A character strobe while the receive-full flag is clear loads the 9-bit character into the data register and sets receive-full on the next clock edge.
- R2: `rx_irq_o` is high exactly when (receive-full and `rx_ie_i`) or (idle and `idle_ie_i`).
- R3: With `nine_bit_i` low, the idle flag sets on the edge of the 10th consecutive bit tick that samples the line high.
- R4: With `nine_bit_i` high, the idle flag sets on the 11th consecutive high bit tick and not on the 10th.
- R5: A low sample at a bit tick restarts the idle count. After idle has set, it does not set again until a character strobe has arrived, however long the line stays high.
- R6: A character strobe while receive-full is set raises the overrun flag. The data register keeps the earlier character, and the noise, framing and parity flags keep their values.
- R7: On an accepted character, noise follows `char_noise_i`, parity error follows `char_parity_err_i`, and framing error is set when `char_stop_i` is 0.
- R8: `err_irq_o` is high exactly when any of overrun, noise, framing or parity is set together with its own enable.
- R9: A flag that is set during a status-read strobe is cleared by the next data-read strobe.
- R10: A flag that sets again between the status read and the data read stays set after the data read.
- R11: After reset, all flags, the data register and both interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_done_i | input | 1 | One-cycle strobe: a character has been assembled |
| char_data_i | input | 9 | Assembled character |
| char_noise_i | input | 1 | Noise seen on some bit of the character |
| char_parity_err_i | input | 1 | Parity check failed for the character |
| char_stop_i | input | 1 | Line level sampled at the stop-bit position |
| bit_tick_i | input | 1 | One-cycle strobe at each bit time |
| line_bit_i | input | 1 | Sampled line level, valid with bit_tick_i |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| status_rd_i | input | 1 | Strobe: CPU read of status |
| data_rd_i | input | 1 | Strobe: CPU read of data register |
| rx_ie_i | input | 1 | Receive-full interrupt enable |
| idle_ie_i | input | 1 | Idle interrupt enable |
| ovr_ie_i | input | 1 | Overrun interrupt enable |
| noise_ie_i | input | 1 | Noise interrupt enable |
| frame_ie_i | input | 1 | Framing error interrupt enable |
| parity_ie_i | input | 1 | Parity error interrupt enable |
| rx_data_o | output | 9 | Receive data register |
| full_o | output | 1 | Receive-full flag |
| idle_o | output | 1 | Idle-line flag |
| overrun_o | output | 1 | Overrun flag |
| noise_o | output | 1 | Noise flag |
| frame_err_o | output | 1 | Framing error flag |
| parity_err_o | output | 1 | Parity error flag |
| rx_irq_o | output | 1 | Receiver interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
A stale clear-arm bit shows up one data read later as a flag that was wrongly cleared or wrongly kept. This is why the bench puts a fresh overrun between the two reads. An off-by-one in the idle counter shifts the idle flag by exactly one bit tick, so the bench samples both the 9th/10th and the 10th/11th tick edges. Overrun mistakes are visible in the very next cycle as a changed data register or changed error flags. Interrupt gating errors are visible within the same cycle, because both request lines are combinational from the flags and the enables.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;
  localparam int NUM_FLAGS    = 6;
  localparam int FLAG_FULL    = 0;
  localparam int FLAG_IDLE    = 1;
  localparam int FLAG_OVR     = 2;
  localparam int FLAG_NOISE   = 3;
  localparam int FLAG_FRAME   = 4;
  localparam int FLAG_PARITY  = 5;
  // flags routed to the receiver request line; the rest go to the error line
  localparam logic [NUM_FLAGS-1:0] RX_GROUP_MASK = 6'b000011;
endpackage

// File: rtl/rx_flag_cell.sv
module rx_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic upd_val_i,
  input  logic status_rd_i,
  input  logic data_rd_i,
  output logic flag_o
);
  logic flag_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (upd_i)                  flag_q <= upd_val_i;
      else if (data_rd_i && arm_q) flag_q <= 1'b0;
      // any update between the two reads disarms the clear
      if (upd_i || data_rd_i)       arm_q <= 1'b0;
      else if (status_rd_i && flag_q) arm_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  assert_clear_armed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && arm_q && !upd_i) |=> !flag_q);
  assert_update_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (flag_q == $past(upd_val_i)));
endmodule

// File: rtl/rx_idle_detect.sv
module rx_idle_detect #(
  parameter int IDLE_SHORT = 10,
  parameter int IDLE_LONG  = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic line_bit_i,
  input  logic nine_bit_i,
  input  logic char_done_i,
  output logic idle_set_o
);
  localparam int CNT_W = $clog2(IDLE_LONG + 1);
  localparam logic [CNT_W-1:0] THR_S = CNT_W'(IDLE_SHORT);
  localparam logic [CNT_W-1:0] THR_L = CNT_W'(IDLE_LONG);

  logic [CNT_W-1:0] cnt_q, thr;
  logic             allow_q, reach;

  assign thr   = nine_bit_i ? THR_L : THR_S;
  assign reach = bit_tick_i && line_bit_i && (cnt_q == thr - CNT_W'(1));
  assign idle_set_o = reach && allow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      allow_q <= 1'b1;
    end else begin
      if (bit_tick_i) begin
        if (!line_bit_i)     cnt_q <= '0;
        else if (cnt_q < thr) cnt_q <= cnt_q + CNT_W'(1);
      end
      if (char_done_i)     allow_q <= 1'b1;
      else if (idle_set_o) allow_q <= 1'b0;
    end
  end

  assert_idle_on_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_set_o |-> (bit_tick_i && line_bit_i));
  assert_idle_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_set_o |=> !idle_set_o);
endmodule

// File: rtl/rx_irq_gate.sv
module rx_irq_gate
  import uart_rx_status_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [NUM_FLAGS-1:0] en_i,
  output logic                 rx_irq_o,
  output logic                 err_irq_o
);
  logic [NUM_FLAGS-1:0] live;
  assign live      = flags_i & en_i;
  assign rx_irq_o  = |(live & RX_GROUP_MASK);
  assign err_irq_o = |(live & ~RX_GROUP_MASK);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_status_pkg::*;
#(
  parameter int DATA_W     = 9,
  parameter int IDLE_SHORT = 10,
  parameter int IDLE_LONG  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_done_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              char_noise_i,
  input  logic              char_parity_err_i,
  input  logic              char_stop_i,
  input  logic              bit_tick_i,
  input  logic              line_bit_i,
  input  logic              nine_bit_i,
  input  logic              status_rd_i,
  input  logic              data_rd_i,
  input  logic              rx_ie_i,
  input  logic              idle_ie_i,
  input  logic              ovr_ie_i,
  input  logic              noise_ie_i,
  input  logic              frame_ie_i,
  input  logic              parity_ie_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              full_o,
  output logic              idle_o,
  output logic              overrun_o,
  output logic              noise_o,
  output logic              frame_err_o,
  output logic              parity_err_o,
  output logic              rx_irq_o,
  output logic              err_irq_o
);
  logic [NUM_FLAGS-1:0] flags, upd, upd_val, en;
  logic [DATA_W-1:0]    data_q;
  logic                 accept, idle_set;

  assign accept = char_done_i && !flags[FLAG_FULL];

  rx_idle_detect #(.IDLE_SHORT(IDLE_SHORT), .IDLE_LONG(IDLE_LONG)) u_idle (
    .clk_i, .rst_ni, .bit_tick_i, .line_bit_i, .nine_bit_i, .char_done_i,
    .idle_set_o(idle_set)
  );

  always_comb begin
    upd     = '0;
    upd_val = '0;
    upd[FLAG_FULL]     = accept;              upd_val[FLAG_FULL]   = 1'b1;
    upd[FLAG_IDLE]     = idle_set;            upd_val[FLAG_IDLE]   = 1'b1;
    upd[FLAG_OVR]      = char_done_i && flags[FLAG_FULL];
    upd_val[FLAG_OVR]  = 1'b1;
    upd[FLAG_NOISE]    = accept;              upd_val[FLAG_NOISE]  = char_noise_i;
    upd[FLAG_FRAME]    = accept;              upd_val[FLAG_FRAME]  = !char_stop_i;
    upd[FLAG_PARITY]   = accept;              upd_val[FLAG_PARITY] = char_parity_err_i;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    rx_flag_cell u_cell (
      .clk_i, .rst_ni,
      .upd_i(upd[g]), .upd_val_i(upd_val[g]),
      .status_rd_i, .data_rd_i,
      .flag_o(flags[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (accept) data_q <= char_data_i;
  end

  always_comb begin
    en = '0;
    en[FLAG_FULL]   = rx_ie_i;
    en[FLAG_IDLE]   = idle_ie_i;
    en[FLAG_OVR]    = ovr_ie_i;
    en[FLAG_NOISE]  = noise_ie_i;
    en[FLAG_FRAME]  = frame_ie_i;
    en[FLAG_PARITY] = parity_ie_i;
  end

  rx_irq_gate u_irq (
    .flags_i(flags), .en_i(en), .rx_irq_o, .err_irq_o
  );

  assign rx_data_o    = data_q;
  assign full_o       = flags[FLAG_FULL];
  assign idle_o       = flags[FLAG_IDLE];
  assign overrun_o    = flags[FLAG_OVR];
  assign noise_o      = flags[FLAG_NOISE];
  assign frame_err_o  = flags[FLAG_FRAME];
  assign parity_err_o = flags[FLAG_PARITY];

  assert_load_char_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_done_i && !full_o) |=> (full_o && rx_data_o == $past(char_data_i)));
  assert_overrun_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_done_i && full_o && !data_rd_i) |=>
      ($stable(rx_data_o) && overrun_o && $stable(noise_o) &&
       $stable(frame_err_o) && $stable(parity_err_o)));
  assert_rx_irq_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ie_i && !idle_ie_i) |-> !rx_irq_o);
  assert_err_irq_ovr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && ovr_ie_i) |-> err_irq_o);
endmodule

// File: tb/uart_rx_status_tb_top.sv
module uart_rx_status_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       char_done = 0, noise_in = 0, par_in = 0, stop_in = 1;
  logic [8:0] char_data = '0;
  logic       tick = 0, line = 1, nine = 0, st_rd = 0, d_rd = 0;
  logic       rx_ie = 0, idle_ie = 0, ovr_ie = 0, noise_ie = 0, frame_ie = 0, par_ie = 0;
  logic [8:0] rx_data;
  logic       full, idle, ovr, noise, frame, parity, rx_irq, err_irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_status dut_i (
    .clk_i(clk), .rst_ni(rst_n), .char_done_i(char_done), .char_data_i(char_data),
    .char_noise_i(noise_in), .char_parity_err_i(par_in), .char_stop_i(stop_in),
    .bit_tick_i(tick), .line_bit_i(line), .nine_bit_i(nine),
    .status_rd_i(st_rd), .data_rd_i(d_rd),
    .rx_ie_i(rx_ie), .idle_ie_i(idle_ie), .ovr_ie_i(ovr_ie), .noise_ie_i(noise_ie),
    .frame_ie_i(frame_ie), .parity_ie_i(par_ie),
    .rx_data_o(rx_data), .full_o(full), .idle_o(idle), .overrun_o(ovr),
    .noise_o(noise), .frame_err_o(frame), .parity_err_o(parity),
    .rx_irq_o(rx_irq), .err_irq_o(err_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic deliver(input logic [8:0] d, input logic n, input logic p, input logic s);
    @(negedge clk);
    char_done = 1; char_data = d; noise_in = n; par_in = p; stop_in = s;
    @(negedge clk);
    char_done = 0; noise_in = 0; par_in = 0; stop_in = 1;
  endtask

  task automatic rd_status();
    @(negedge clk); st_rd = 1; @(negedge clk); st_rd = 0;
  endtask

  task automatic rd_data();
    @(negedge clk); d_rd = 1; @(negedge clk); d_rd = 0;
  endtask

  task automatic clear_seq();
    rd_status(); rd_data();
  endtask

  task automatic bit_time(input logic v);
    @(negedge clk); tick = 1; line = v; @(negedge clk); tick = 0; line = 1;
  endtask

  task automatic set_en(input logic a, b, c, d, e, f);
    @(negedge clk);
    rx_ie = a; idle_ie = b; ovr_ie = c; noise_ie = d; frame_ie = e; par_ie = f;
    #1;
  endtask

  task automatic t_reset();
    check("R11 data", rx_data, 0);
    check("R11 flags", {full, idle, ovr, noise, frame, parity}, 0);
    check("R11 irqs", {rx_irq, err_irq}, 0);
  endtask

  task automatic t_receive();
    deliver(9'h0A5, 0, 0, 1);
    check("R1 full", full, 1);
    check("R1 data", rx_data, 9'h0A5);
    check("R2 rx irq off", rx_irq, 0);
    set_en(1, 0, 0, 0, 0, 0);
    check("R2 rx irq on", rx_irq, 1);
    set_en(0, 0, 0, 0, 0, 0);
    rd_status();
    check("R9 full held after status read", full, 1);
    rd_data();
    check("R9 full cleared", full, 0);
  endtask

  task automatic t_overrun();
    deliver(9'h011, 0, 0, 1);
    deliver(9'h022, 1, 1, 0);
    check("R6 overrun", ovr, 1);
    check("R6 data kept", rx_data, 9'h011);
    check("R6 err flags kept", {noise, frame, parity}, 0);
    set_en(0, 0, 1, 0, 0, 0);
    check("R8 ovr enabled", err_irq, 1);
    set_en(0, 0, 0, 1, 1, 1);
    check("R8 ovr masked", err_irq, 0);
    set_en(0, 0, 0, 0, 0, 0);
    clear_seq();
    check("R9 full+ovr cleared", {full, ovr}, 0);
  endtask

  task automatic t_errors();
    deliver(9'h1FF, 1, 1, 0);
    check("R7 data 9 bit", rx_data, 9'h1FF);
    check("R7 noise/frame/parity", {noise, frame, parity}, 3'b111);
    set_en(0, 0, 0, 1, 0, 0); check("R8 noise", err_irq, 1);
    set_en(0, 0, 0, 0, 1, 0); check("R8 frame", err_irq, 1);
    set_en(0, 0, 0, 0, 0, 1); check("R8 parity", err_irq, 1);
    set_en(1, 1, 0, 0, 0, 0); check("R8 none", err_irq, 0);
    set_en(0, 0, 0, 0, 0, 0);
    clear_seq();
    check("R9 errors cleared", {full, noise, frame, parity}, 0);
    deliver(9'h003, 0, 1, 1);
    check("R7 parity only", {noise, frame, parity}, 3'b001);
    clear_seq();
  endtask

  task automatic t_reset_between_reads();
    deliver(9'h033, 0, 0, 1);
    deliver(9'h044, 0, 0, 1);
    rd_status();
    deliver(9'h055, 0, 0, 1);
    rd_data();
    check("R10 full cleared", full, 0);
    check("R10 overrun stays", ovr, 1);
    check("R10 data", rx_data, 9'h033);
    clear_seq();
    check("R9 overrun cleared", ovr, 0);
  endtask

  task automatic t_idle();
    nine = 0;
    bit_time(0);
    for (int i = 0; i < 9; i++) bit_time(1);
    check("R3 no idle at 9", idle, 0);
    bit_time(1);
    check("R3 idle at 10", idle, 1);
    set_en(0, 1, 0, 0, 0, 0);
    check("R2 idle irq", rx_irq, 1);
    set_en(0, 0, 0, 0, 0, 0);
    clear_seq();
    check("R9 idle cleared", idle, 0);
    for (int i = 0; i < 20; i++) bit_time(1);
    check("R5 no re-set", idle, 0);
    deliver(9'h066, 0, 0, 1);
    clear_seq();
    bit_time(0);
    for (int i = 0; i < 5; i++) bit_time(1);
    bit_time(0);
    for (int i = 0; i < 9; i++) bit_time(1);
    check("R5 restart on low", idle, 0);
    bit_time(1);
    check("R5 idle after restart", idle, 1);
    clear_seq();
    deliver(9'h077, 0, 0, 1);
    clear_seq();
    nine = 1;
    bit_time(0);
    for (int i = 0; i < 10; i++) bit_time(1);
    check("R4 no idle at 10", idle, 0);
    bit_time(1);
    check("R4 idle at 11", idle, 1);
    clear_seq();
    nine = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_receive();
    t_overrun();
    t_errors();
    t_reset_between_reads();
    t_idle();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule